// File: doc/BRIEF.md
# Byte-Addressed Data Memory Port

This unit sits between a small RISC core and its local data memory. Loads never carry an address of their own. The byte address always comes from register 15 of the register file, and the unit samples that register one cycle late. A load therefore sees the register-15 value that was present on the cycle before the load was issued. A load that directly follows a store does not use register 15 at all. It reuses the byte address of that store.

Loads may fetch a byte, a halfword or a full word. Byte and halfword lanes are taken from the low address bits in little-endian order. The result is zero- or sign-extended to 32 bits and returned to the register file, together with the destination index given with the load. Stores always write a full 32-bit word to the word-aligned location. The unit holds a synchronous single-port RAM. Load data appears on the write-back port one cycle after the request.

Top module: `dram_port`

## Requirements
- R1: A load in cycle t uses the register-15 value that was sampled in cycle t-1. This holds unless R3 applies.
- R2: Addresses are byte addresses. The word index is bits [IDX_W+1:2], which are bits [11:2] at the default depth of 1024 words. Higher address bits are ignored.
- R3: A load issued on the cycle right after a store uses that store's full byte address, whatever register 15 holds.
- R4: A store writes all 32 bits of the write data to the word selected by the delayed register-15 value. Address bits [1:0] are ignored.
- R5: A byte load (size code 2'b00) returns bits [8k+7:8k] of the word, where k is address bits [1:0].
- R6: A halfword load (size code 2'b01) returns bits [31:16] when address bit 1 is set and bits [15:0] when it is clear. Address bit 0 is ignored.
- R7: A word load (size codes 2'b10 and 2'b11) returns the whole word. Address bits [1:0] are ignored.
- R8: When the sign-extension input is 1, a narrow result is sign-extended to 32 bits. When it is 0, the result is zero-extended.
- R9: The write-back valid output is high in exactly the cycle after an accepted load. In that cycle the write-back destination equals the destination index given with the load.
- R10: When load and store strobes are high together, only the store is performed and no write-back follows.
- R11: After reset, the write-back valid output is low and the delayed address is zero. A store issued on the first cycle after reset therefore goes to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r15_val | input | ADDR_W | Current register-15 value (byte address) |
| rd_en | input | 1 | Load strobe |
| wr_en | input | 1 | Store strobe |
| rd_size | input | 2 | Load size: 00 byte, 01 halfword, 1x word |
| rd_sext | input | 1 | 1 sign-extends, 0 zero-extends |
| wr_data | input | 32 | Store data |
| rd_dest | input | DEST_W | Register-file destination of the load |
| wb_valid | output | 1 | Load result valid |
| wb_dest | output | DEST_W | Destination index of the result |
| wb_data | output | 32 | Extended load result |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 1024 words and 4-bit destination indices. With these values a register-15 value that carries stray upper bits must still land in the low words. Stores and loads are confined to the first sixteen words, so every load reads a location that was written earlier. Random runs with back-to-back store/load pairs, misaligned store addresses and changing register-15 values then exercise the one-cycle address delay and the address reuse after a store in every combination of lane and extension.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int WORD_BITS = 32;
    localparam int LANE_BITS = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } size_e;

    // Lane selection carried alongside a load through the RAM stage
    typedef struct packed {
        size_e                size;
        logic                 sext;
        logic [LANE_BITS-1:0] lane;
    } lane_sel_t;

    function automatic logic [WORD_BITS-1:0] pick_lane(
        input logic [WORD_BITS-1:0] word,
        input lane_sel_t            sel
    );
        logic [7:0]  b;
        logic [15:0] h;
        b = word[8*sel.lane +: 8];
        h = sel.lane[1] ? word[31:16] : word[15:0];
        case (sel.size)
            SZ_BYTE: return {{24{sel.sext & b[7]}}, b};
            SZ_HALF: return {{16{sel.sext & h[15]}}, h};
            default: return word;
        endcase
    endfunction

endpackage

// File: rtl/dram_addr_pipe.sv
module dram_addr_pipe #(
    parameter int BA_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BA_W-1:0] r15_lo,
    input  logic            st_fire,
    output logic [BA_W-1:0] st_addr,
    output logic [BA_W-1:0] ld_addr
);
    logic [BA_W-1:0] r15_dly;
    logic [BA_W-1:0] last_st;
    logic            st_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            r15_dly <= '0;
            last_st <= '0;
            st_prev <= 1'b0;
        end else begin
            r15_dly <= r15_lo;
            st_prev <= st_fire;
            if (st_fire) last_st <= r15_dly;
        end
    end

    assign st_addr = r15_dly;
    // a load right after a store repeats that store's byte address
    assign ld_addr = st_prev ? last_st : r15_dly;

endmodule

// File: rtl/dram_array.sv
module dram_array #(
    parameter int WORDS = 1024,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        else if (re) rdata <= mem[idx];
    end

endmodule

// File: rtl/dram_lane_ext.sv
module dram_lane_ext
    import dram_pkg::*;
(
    input  logic [WORD_BITS-1:0] word,
    input  lane_sel_t            sel,
    output logic [WORD_BITS-1:0] result
);
    always_comb result = pick_lane(word, sel);
endmodule

// File: rtl/dram_port.sv
module dram_port
    import dram_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 1024,
    parameter int DEST_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    r15_val,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [1:0]           rd_size,
    input  logic                 rd_sext,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic [DEST_W-1:0]    rd_dest,
    output logic                 wb_valid,
    output logic [DEST_W-1:0]    wb_dest,
    output logic [WORD_BITS-1:0] wb_data
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int BA_W  = IDX_W + LANE_BITS;

    logic [BA_W-1:0]      st_addr, ld_addr;
    logic                 ld_fire;
    logic [IDX_W-1:0]     ram_idx;
    logic [WORD_BITS-1:0] ram_q;
    lane_sel_t            sel_q;
    logic [DEST_W-1:0]    dest_q;
    logic                 valid_q;

    logic unused_hi_bits;
    generate
        if (ADDR_W > BA_W) begin : g_hi
            assign unused_hi_bits = ^r15_val[ADDR_W-1:BA_W];
        end else begin : g_nohi
            assign unused_hi_bits = 1'b0;
        end
    endgenerate

    assign ld_fire = rd_en & ~wr_en;

    dram_addr_pipe #(.BA_W(BA_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .r15_lo  (r15_val[BA_W-1:0]),
        .st_fire (wr_en),
        .st_addr (st_addr),
        .ld_addr (ld_addr)
    );

    assign ram_idx = wr_en ? st_addr[BA_W-1:LANE_BITS] : ld_addr[BA_W-1:LANE_BITS];

    dram_array #(.WORDS(WORDS), .DW(WORD_BITS)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .re    (ld_fire),
        .idx   (ram_idx),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dest_q  <= '0;
            sel_q   <= '0;
        end else begin
            valid_q <= ld_fire;
            if (ld_fire) begin
                dest_q     <= rd_dest;
                sel_q.size <= size_e'(rd_size);
                sel_q.sext <= rd_sext;
                sel_q.lane <= ld_addr[LANE_BITS-1:0];
            end
        end
    end

    dram_lane_ext u_ext (
        .word   (ram_q),
        .sel    (sel_q),
        .result (wb_data)
    );

    assign wb_valid = valid_q;
    assign wb_dest  = dest_q;

endmodule

// File: rtl/dram_port_chk.sv
module dram_port_chk #(
    parameter int DEST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        rd_size,
    input logic              rd_sext,
    input logic [DEST_W-1:0] rd_dest,
    input logic              wb_valid,
    input logic [DEST_W-1:0] wb_dest,
    input logic [31:0]       wb_data
);
    AST_LOAD_GIVES_WB: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> wb_valid); // R9
    AST_NO_STRAY_WB: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || wr_en) |=> !wb_valid); // R10
    AST_DEST_CARRIED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> (wb_dest == $past(rd_dest))); // R9
    AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && rd_size == 2'b00 && !rd_sext) |=> (wb_data[31:8] == 24'h0)); // R8
    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && rd_size == 2'b01 && rd_sext) |=> (wb_data[31:16] == {16{wb_data[15]}})); // R8
endmodule

bind dram_port dram_port_chk #(.DEST_W(DEST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rd_size  (rd_size),
    .rd_sext  (rd_sext),
    .rd_dest  (rd_dest),
    .wb_valid (wb_valid),
    .wb_dest  (wb_dest),
    .wb_data  (wb_data)
);

// File: tb/tb_dram_port.sv
`timescale 1ns/1ps
module tb_dram_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] r15_val = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, rd_sext = 1'b0;
    logic [1:0]  rd_size = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_dest = '0;
    logic        wb_valid;
    logic [3:0]  wb_dest;
    logic [31:0] wb_data;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [31:0] ref_mem [1024];
    logic [31:0] ref_r15_old = '0;
    logic [31:0] ref_st_addr = '0;
    bit          ref_st_prev = 0;
    bit          ex_valid = 0;
    logic [3:0]  ex_dest = '0;
    logic [31:0] ex_data = '0;

    always #5 clk = ~clk;

    dram_port dut (
        .clk(clk), .rst(rst), .r15_val(r15_val), .rd_en(rd_en), .wr_en(wr_en),
        .rd_size(rd_size), .rd_sext(rd_sext), .wr_data(wr_data), .rd_dest(rd_dest),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data)
    );

    function automatic logic [31:0] expect_load(logic [31:0] w, logic [31:0] a,
                                                logic [1:0] sz, logic sx);
        logic [31:0] v;
        if (sz == 2'b00) begin
            v = (w >> (8 * a[1:0])) & 32'hFF;
            if (sx && v[7]) v = v | 32'hFFFF_FF00;
        end else if (sz == 2'b01) begin
            v = (w >> (a[1] ? 16 : 0)) & 32'hFFFF;
            if (sx && v[15]) v = v | 32'hFFFF_0000;
        end else v = w;
        return v;
    endfunction

    task automatic step(input string tag, input logic [31:0] r15, input logic rd,
                        input logic wr, input logic [1:0] sz, input logic sx,
                        input logic [31:0] wd, input logic [3:0] dst);
        logic [31:0] ld_a;
        r15_val = r15; rd_en = rd; wr_en = wr; rd_size = sz;
        rd_sext = sx; wr_data = wd; rd_dest = dst;
        @(posedge clk);
        #1;
        ld_a = ref_st_prev ? ref_st_addr : ref_r15_old;
        ex_valid = rd && !wr;
        if (wr) begin
            ref_mem[ref_r15_old[11:2]] = wd;
            ref_st_addr = ref_r15_old;
        end else if (rd) begin
            ex_dest = dst;
            ex_data = expect_load(ref_mem[ld_a[11:2]], ld_a, sz, sx);
        end
        ref_st_prev = wr;
        ref_r15_old = r15;
        @(negedge clk);
        checks++;
        if (wb_valid !== ex_valid) begin
            errors++;
            $display("FAIL %s wb_valid got %b exp %b", tag, wb_valid, ex_valid);
        end else if (ex_valid && (wb_dest !== ex_dest || wb_data !== ex_data)) begin
            errors++;
            $display("FAIL %s dest/data got %h/%h exp %h/%h", tag, wb_dest, wb_data,
                     ex_dest, ex_data);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (wb_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 wb_valid got %b exp 0", wb_valid);
        end
        // R11: store on the first cycle after reset lands in word 0
        step("R11", 32'h40, 0, 1, 2'b10, 0, 32'hDEAD_BEEF, 4'h0);
        step("R11", 32'h0, 0, 0, 2'b10, 0, 32'h0, 4'h0);
        step("R11", 32'h0, 1, 0, 2'b10, 0, 32'h0, 4'h3);
        // R4: fill words 0..15 through misaligned addresses, back-to-back stores
        step("R4", 32'h3, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        for (int i = 0; i < 16; i++)
            step("R4", ((i + 1) * 4) | ((i * 3) & 3), 0, 1, 2'b00, 0,
                 32'h80FF_7F01 ^ (i * 32'h9E37_79B1), 4'h0);
        // R5, R8: every byte lane, both extensions
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 2; s++) begin
                step("R5", 32'h14 + k, 0, 0, 2'b00, 0, 32'h0, 4'h0);
                step("R8", 32'h14 + k, 1, 0, 2'b00, s[0], 32'h0, 4'(k + 1));
            end
        // R6, R8: halfword lanes, bit 0 ignored
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 2; s++) begin
                step("R6", 32'h8 + k, 0, 0, 2'b00, 0, 32'h0, 4'h0);
                step("R6", 32'h8 + k, 1, 0, 2'b01, s[0], 32'h0, 4'h7);
            end
        // R7: whole word, both codes
        step("R7", 32'h1F, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        step("R7", 32'h1F, 1, 0, 2'b11, 1, 32'h0, 4'h9);
        step("R7", 32'h1E, 1, 0, 2'b10, 0, 32'h0, 4'hA);
        // R1: load uses the previous cycle's register-15 value
        step("R1", 32'h24, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        step("R1", 32'h30, 1, 0, 2'b10, 0, 32'h0, 4'hB);
        // R3: load right after a store reuses the store address
        step("R3", 32'h35, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        step("R3", 32'h08, 0, 1, 2'b00, 0, 32'hC0DE_F00D, 4'h0);
        step("R3", 32'h3C, 1, 0, 2'b00, 1, 32'h0, 4'hC);
        // R10: simultaneous strobes store only
        step("R10", 32'h10, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        step("R10", 32'h10, 1, 1, 2'b10, 0, 32'h1234_5678, 4'hD);
        step("R10", 32'h10, 1, 0, 2'b10, 0, 32'h0, 4'hE);
        // R2: stray upper address bits are ignored
        step("R2", 32'hABCD_0004, 0, 0, 2'b00, 0, 32'h0, 4'h0);
        step("R2", 32'h7700_0006, 1, 0, 2'b01, 1, 32'h0, 4'h5);
        // R9: random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            int c;
            a = $urandom_range(0, 63);
            if ($urandom_range(0, 1) == 1) a = a | ($urandom() & 32'hFFFF_F000);
            c = $urandom_range(0, 9);
            step("R9", a, c < 6 || c == 9, c >= 6, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), $urandom(), 4'($urandom_range(0, 15)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule